// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel Sequencer

This block is the control sequencer for one DMA channel that works from a linked list of descriptors held in memory. Software points it at the first descriptor, holds the channel enable high and pulses a start strobe. The sequencer then reads each descriptor as four words over a simple word-read port. It hands the transfer that the descriptor describes to an external data mover and waits for the mover's completion pulse. If clear-count mode is on, it writes a zero back over the descriptor's count word. It then follows the next-pointer until it reaches a descriptor marked as the last one.

The block does not move any data itself. The data mover, its buffers and the bus protocols on either side sit outside it. The sequencer only produces the address pair, the byte count and the direction of each transfer. It also handles ring operation through a per-descriptor valid flag. Valid descriptors with a zero count are skipped. A descriptor that is not yet valid is either polled again or parks the channel until software restarts it. Done and interrupt outputs report progress, and an abort path is provided for a channel that software has disabled.

Top module: `sgdma_seq`

## Requirements
- R1: A descriptor at a 16-byte-aligned base is read as four words, in this order: PCI address at base+0, local address at base+4, count word at base+8, next-pointer word at base+12. The address space of the first descriptor comes from `first_space_i`. The space of each later descriptor comes from bit 0 of the previous next-pointer word (1 = PCI space, 0 = local space). The next base is next-pointer bits 31:4 followed by four zero bits.
- R2: Each descriptor with a nonzero count causes exactly one `mv_start_o` pulse. With it go the PCI address, the local address, the count (count-word bits 30:0) and the direction (next-pointer bit 3; 1 = local-to-PCI, 0 = PCI-to-local). Transfers follow chain order. No descriptor read is issued while a transfer is open, that is, after `mv_start_o` and before `mv_done_i` or `mv_abort_o`.
- R3: When a descriptor with end-of-chain set (next-pointer bit 1) completes, the channel goes idle and `done_o` becomes 1. `irq_o` is raised at the same time only if `mode_done_ie_i` is 1.
- R4: If next-pointer bit 2 is set, `irq_o` is raised when that descriptor completes, whatever the value of `mode_done_ie_i`.
- R5: With `mode_ring_i` at 0, the valid flag (count-word bit 31) is ignored. A descriptor whose flag is 0 is still transferred.
- R6: With `mode_ring_i` at 1, a valid descriptor with a zero count never starts the mover. If it is not end-of-chain, the sequencer goes straight on to the next descriptor and does not write it back. If it is end-of-chain, the channel completes as in R3.
- R7: With `mode_ring_i` at 1 and `mode_vstop_i` at 0, a descriptor whose valid flag reads 0 is read again, all four words each time, until the flag reads 1. The transfer then proceeds.
- R8: With `mode_ring_i` at 1 and `mode_vstop_i` at 1, an invalid descriptor parks the channel. The channel stays busy, issues no reads and starts no transfer until `start_i` is pulsed while `en_i` is 1. It then reads the same descriptor again.
- R9: With `mode_clrcnt_i` at 1, each completed descriptor has zero written to its count word at base+8 in its own address space. With the mode at 0, nothing is written. Ring mode must only be used together with clear-count mode.
- R10: `start_i` has no effect while `en_i` is 0. An accepted start from idle clears `done_o`.
- R11: While `en_i` is 0 during an open transfer, `mv_hold_o` is 1 and the channel does not finish. When `en_i` returns to 1, the chain resumes and completes.
- R12: `abort_i` is ignored while `en_i` is 1. With `en_i` at 0 on a busy channel, an abort returns the channel to idle, sets `done_o` and pulses `mv_abort_o` for one cycle.
- R13: A `clr_irq_i` pulse clears `irq_o` and leaves `done_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Channel enable level |
| start_i | input | 1 | Start strobe, one cycle |
| abort_i | input | 1 | Abort strobe, one cycle |
| clr_irq_i | input | 1 | Interrupt clear strobe, one cycle |
| mode_ring_i | input | 1 | Ring valid-flag mode |
| mode_vstop_i | input | 1 | Invalid descriptor parks the channel (1) or is polled (0) |
| mode_clrcnt_i | input | 1 | Write back a zero count word on completion |
| mode_done_ie_i | input | 1 | Raise interrupt at end of chain |
| first_hi_i | input | AW-4 | Address bits AW-1:4 of the first descriptor |
| first_space_i | input | 1 | Space of the first descriptor (1 = PCI) |
| rd_req_o | output | 1 | Descriptor word read request, held until acknowledged |
| rd_space_o | output | 1 | Read address space |
| rd_addr_o | output | AW | Read byte address |
| rd_ack_i | input | 1 | Read acknowledge, qualifies rd_data_i |
| rd_data_i | input | DW | Read data |
| wr_req_o | output | 1 | Count write-back request, held until acknowledged |
| wr_space_o | output | 1 | Write address space |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | DW | Write data (zero) |
| wr_ack_i | input | 1 | Write acknowledge |
| mv_start_o | output | 1 | One-cycle transfer launch |
| mv_pci_addr_o | output | AW | Transfer PCI-side address |
| mv_loc_addr_o | output | AW | Transfer local-side address |
| mv_count_o | output | DW-1 | Transfer byte count |
| mv_dir_o | output | 1 | 1 = local-to-PCI |
| mv_hold_o | output | 1 | Pause request to the mover |
| mv_abort_o | output | 1 | One-cycle abort of the open transfer |
| mv_done_i | input | 1 | Mover completion pulse |
| busy_o | output | 1 | Channel not idle |
| done_o | output | 1 | Chain finished or aborted |
| irq_o | output | 1 | Channel interrupt pending |

## Verification
The bench goes after the ring cases. It checks a zero-count valid descriptor in the middle of a chain: a sequencer that launched it would hand a zero count to the mover, and one that wrote it back would clear a flag the ring still needs. It checks an invalid descriptor under both stop settings: a wrong design would either spin when it should park, shown by a growing read count, or stall when it should poll. It also checks that the valid flag is ignored outside ring mode, that a pause holds the mover instead of finishing, that an abort strobe is ignored while enabled, and that the interrupt sources stay separate. A design that mixed these up would raise an interrupt with the done-interrupt enable off and no per-descriptor request.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_FETCH,
      S_EVAL,
      S_LAUNCH,
      S_XFER,
      S_WB,
      S_CMPL,
      S_NEXT,
      S_STOP
   } sg_state_t;

   localparam int unsigned DESC_WORDS = 4;
   localparam int unsigned ALIGN      = 4;

   localparam int unsigned W_PCI = 0;
   localparam int unsigned W_LOC = 1;
   localparam int unsigned W_CNT = 2;
   localparam int unsigned W_NXT = 3;

   localparam int unsigned NB_SPACE = 0;
   localparam int unsigned NB_EOC   = 1;
   localparam int unsigned NB_TC    = 2;
   localparam int unsigned NB_DIR   = 3;

endpackage

// File: rtl/sgdma_desc_store.sv
module sgdma_desc_store
   import sgdma_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32,
   localparam int unsigned CW = DW - 1,
   localparam int unsigned HW = AW - ALIGN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_i,
   input  logic [1:0]    sel_i,
   input  logic [DW-1:0] word_i,
   output logic [AW-1:0] pci_o,
   output logic [AW-1:0] loc_o,
   output logic [CW-1:0] cnt_o,
   output logic          valid_o,
   output logic          eoc_o,
   output logic          tc_o,
   output logic          dir_o,
   output logic          nspace_o,
   output logic [HW-1:0] nhi_o
);

   logic [DW-1:0] words_q [DESC_WORDS];

   for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            words_q[w] <= '0;
         end else if (cap_i && (sel_i == 2'(w))) begin
            words_q[w] <= word_i;
         end
      end
   end

   if (AW == DW) begin : g_full_addr
      assign pci_o = words_q[W_PCI];
      assign loc_o = words_q[W_LOC];
   end else begin : g_narrow_addr
      assign pci_o = words_q[W_PCI][AW-1:0];
      assign loc_o = words_q[W_LOC][AW-1:0];
   end

   assign cnt_o    = words_q[W_CNT][CW-1:0];
   assign valid_o  = words_q[W_CNT][DW-1];
   assign nspace_o = words_q[W_NXT][NB_SPACE];
   assign eoc_o    = words_q[W_NXT][NB_EOC];
   assign tc_o     = words_q[W_NXT][NB_TC];
   assign dir_o    = words_q[W_NXT][NB_DIR];
   assign nhi_o    = words_q[W_NXT][AW-1:ALIGN];

endmodule

// File: rtl/sgdma_status.sv
module sgdma_status (
   input  logic clk,
   input  logic rst_n,
   input  logic accept_i,
   input  logic fin_i,
   input  logic abort_i,
   input  logic tc_evt_i,
   input  logic done_ie_i,
   input  logic clr_i,
   output logic done_o,
   output logic irq_o
);

   logic irq_set;

   assign irq_set = tc_evt_i | (fin_i & done_ie_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         irq_o  <= 1'b0;
      end else begin
         if (fin_i || abort_i) begin
            done_o <= 1'b1;
         end else if (accept_i) begin
            done_o <= 1'b0;
         end
         irq_o <= (irq_o & ~clr_i) | irq_set;
      end
   end

endmodule

// File: rtl/sgdma_fsm.sv
module sgdma_fsm
   import sgdma_pkg::*;
#(
   parameter int unsigned AW = 32,
   localparam int unsigned HW = AW - ALIGN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          start_i,
   input  logic          abort_i,
   input  logic          ring_i,
   input  logic          vstop_i,
   input  logic          clrcnt_i,
   input  logic [HW-1:0] first_hi_i,
   input  logic          first_space_i,
   input  logic          rd_ack_i,
   input  logic          wr_ack_i,
   input  logic          mv_done_i,
   input  logic          d_valid_i,
   input  logic          d_cnt_zero_i,
   input  logic          d_eoc_i,
   input  logic          d_tc_i,
   input  logic          d_nspace_i,
   input  logic [HW-1:0] d_nhi_i,
   output logic          rd_req_o,
   output logic          wr_req_o,
   output logic [AW-1:0] acc_addr_o,
   output logic          acc_space_o,
   output logic          cap_o,
   output logic [1:0]    sel_o,
   output logic          mv_start_o,
   output logic          mv_hold_o,
   output logic          mv_abort_o,
   output logic          busy_o,
   output logic          accept_o,
   output logic          fin_o,
   output logic          abort_done_o,
   output logic          tc_evt_o
);

   sg_state_t     state_q;
   logic [1:0]    idx_q;
   logic [HW-1:0] base_hi_q;
   logic          space_q;
   logic          start_q;
   logic          abort_q;
   logic          abort_hit;
   logic [1:0]    word_off;

   assign abort_hit = abort_i && !en_i && (state_q != S_IDLE);
   assign word_off  = (state_q == S_WB) ? 2'(W_CNT) : idx_q;

   assign rd_req_o     = (state_q == S_FETCH);
   assign wr_req_o     = (state_q == S_WB);
   assign acc_addr_o   = {base_hi_q, word_off, 2'b00};
   assign acc_space_o  = space_q;
   assign cap_o        = (state_q == S_FETCH) && rd_ack_i;
   assign sel_o        = idx_q;
   assign mv_start_o   = start_q;
   assign mv_abort_o   = abort_q;
   assign mv_hold_o    = (state_q == S_XFER) && !en_i;
   assign busy_o       = (state_q != S_IDLE);
   assign accept_o     = (state_q == S_IDLE) && start_i && en_i;
   assign fin_o        = (state_q == S_CMPL) && d_eoc_i && !abort_hit;
   assign tc_evt_o     = (state_q == S_CMPL) && d_tc_i && !abort_hit;
   assign abort_done_o = abort_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         idx_q     <= '0;
         base_hi_q <= '0;
         space_q   <= 1'b0;
         start_q   <= 1'b0;
         abort_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         abort_q <= 1'b0;
         if (abort_hit) begin
            state_q <= S_IDLE;
            abort_q <= 1'b1;
         end else begin
            case (state_q)
               S_IDLE: begin
                  if (start_i && en_i) begin
                     base_hi_q <= first_hi_i;
                     space_q   <= first_space_i;
                     idx_q     <= '0;
                     state_q   <= S_FETCH;
                  end
               end
               S_FETCH: begin
                  if (rd_ack_i) begin
                     idx_q <= idx_q + 2'd1;
                     if (idx_q == 2'(W_NXT)) state_q <= S_EVAL;
                  end
               end
               S_EVAL: begin
                  if (ring_i && !d_valid_i) begin
                     state_q <= vstop_i ? S_STOP : S_NEXT;
                  end else if (d_cnt_zero_i) begin
                     if (d_eoc_i) begin
                        state_q <= clrcnt_i ? S_WB : S_CMPL;
                     end else begin
                        base_hi_q <= d_nhi_i;
                        space_q   <= d_nspace_i;
                        state_q   <= S_NEXT;
                     end
                  end else begin
                     state_q <= S_LAUNCH;
                  end
               end
               S_LAUNCH: begin
                  if (en_i) begin
                     start_q <= 1'b1;
                     state_q <= S_XFER;
                  end
               end
               S_XFER: begin
                  if (mv_done_i) state_q <= clrcnt_i ? S_WB : S_CMPL;
               end
               S_WB: begin
                  if (wr_ack_i) state_q <= S_CMPL;
               end
               S_CMPL: begin
                  if (d_eoc_i) begin
                     state_q <= S_IDLE;
                  end else begin
                     base_hi_q <= d_nhi_i;
                     space_q   <= d_nspace_i;
                     state_q   <= S_NEXT;
                  end
               end
               S_NEXT: begin
                  if (en_i) begin
                     idx_q   <= '0;
                     state_q <= S_FETCH;
                  end
               end
               S_STOP: begin
                  if (start_i && en_i) begin
                     idx_q   <= '0;
                     state_q <= S_FETCH;
                  end
               end
               default: state_q <= S_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
   import sgdma_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32,
   localparam int unsigned CW = DW - 1,
   localparam int unsigned HW = AW - ALIGN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          start_i,
   input  logic          abort_i,
   input  logic          clr_irq_i,
   input  logic          mode_ring_i,
   input  logic          mode_vstop_i,
   input  logic          mode_clrcnt_i,
   input  logic          mode_done_ie_i,
   input  logic [HW-1:0] first_hi_i,
   input  logic          first_space_i,
   output logic          rd_req_o,
   output logic          rd_space_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_ack_i,
   input  logic [DW-1:0] rd_data_i,
   output logic          wr_req_o,
   output logic          wr_space_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o,
   input  logic          wr_ack_i,
   output logic          mv_start_o,
   output logic [AW-1:0] mv_pci_addr_o,
   output logic [AW-1:0] mv_loc_addr_o,
   output logic [CW-1:0] mv_count_o,
   output logic          mv_dir_o,
   output logic          mv_hold_o,
   output logic          mv_abort_o,
   input  logic          mv_done_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          irq_o
);

   if (AW > DW) begin : g_chk_aw
      $error("sgdma_seq: AW must not exceed DW");
   end
   if (AW <= ALIGN + 1) begin : g_chk_align
      $error("sgdma_seq: AW too small for aligned descriptors");
   end
   if (DW < 8) begin : g_chk_dw
      $error("sgdma_seq: DW too small for flag layout");
   end

   logic          cap, d_valid, d_eoc, d_tc, d_nspace;
   logic [1:0]    sel;
   logic [HW-1:0] d_nhi;
   logic [CW-1:0] d_cnt;
   logic [AW-1:0] acc_addr;
   logic          acc_space;
   logic          accept, fin, abort_done, tc_evt;

   sgdma_desc_store #(.AW(AW), .DW(DW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_i    (cap),
      .sel_i    (sel),
      .word_i   (rd_data_i),
      .pci_o    (mv_pci_addr_o),
      .loc_o    (mv_loc_addr_o),
      .cnt_o    (d_cnt),
      .valid_o  (d_valid),
      .eoc_o    (d_eoc),
      .tc_o     (d_tc),
      .dir_o    (mv_dir_o),
      .nspace_o (d_nspace),
      .nhi_o    (d_nhi)
   );

   sgdma_fsm #(.AW(AW)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_i          (en_i),
      .start_i       (start_i),
      .abort_i       (abort_i),
      .ring_i        (mode_ring_i),
      .vstop_i       (mode_vstop_i),
      .clrcnt_i      (mode_clrcnt_i),
      .first_hi_i    (first_hi_i),
      .first_space_i (first_space_i),
      .rd_ack_i      (rd_ack_i),
      .wr_ack_i      (wr_ack_i),
      .mv_done_i     (mv_done_i),
      .d_valid_i     (d_valid),
      .d_cnt_zero_i  (d_cnt == '0),
      .d_eoc_i       (d_eoc),
      .d_tc_i        (d_tc),
      .d_nspace_i    (d_nspace),
      .d_nhi_i       (d_nhi),
      .rd_req_o      (rd_req_o),
      .wr_req_o      (wr_req_o),
      .acc_addr_o    (acc_addr),
      .acc_space_o   (acc_space),
      .cap_o         (cap),
      .sel_o         (sel),
      .mv_start_o    (mv_start_o),
      .mv_hold_o     (mv_hold_o),
      .mv_abort_o    (mv_abort_o),
      .busy_o        (busy_o),
      .accept_o      (accept),
      .fin_o         (fin),
      .abort_done_o  (abort_done),
      .tc_evt_o      (tc_evt)
   );

   sgdma_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .fin_i     (fin),
      .abort_i   (abort_done),
      .tc_evt_i  (tc_evt),
      .done_ie_i (mode_done_ie_i),
      .clr_i     (clr_irq_i),
      .done_o    (done_o),
      .irq_o     (irq_o)
   );

   assign mv_count_o = d_cnt;
   assign rd_addr_o  = acc_addr;
   assign rd_space_o = acc_space;
   assign wr_addr_o  = acc_addr;
   assign wr_space_o = acc_space;
   assign wr_data_o  = '0;

endmodule

// File: rtl/sgdma_seq_chk.sv
module sgdma_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic start_i,
   input logic abort_i,
   input logic clr_irq_i,
   input logic mode_ring_i,
   input logic mode_clrcnt_i,
   input logic rd_req_o,
   input logic wr_req_o,
   input logic mv_start_o,
   input logic mv_hold_o,
   input logic mv_abort_o,
   input logic mv_done_i,
   input logic busy_o,
   input logic done_o,
   input logic irq_o
);

   logic open_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                      open_q <= 1'b0;
      else if (mv_start_o)             open_q <= 1'b1;
      else if (mv_done_i || mv_abort_o) open_q <= 1'b0;
   end

   p_no_fetch_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> !open_q);

   p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mv_start_o |=> !mv_start_o);

   p_launch_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mv_start_o |-> $past(en_i));

   p_hold_only_paused_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mv_hold_o |-> (!en_i && busy_o));

   p_wb_needs_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> mode_clrcnt_i);

   p_ring_with_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && en_i && mode_ring_i) |-> mode_clrcnt_i);

   p_done_clear_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_o) |-> $past(start_i && en_i));

   p_abort_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i && en_i && busy_o) |=> !mv_abort_o);

   p_abort_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mv_abort_o |-> (done_o && !busy_o));

   p_irq_clear_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(clr_irq_i));

endmodule

bind sgdma_seq sgdma_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en_i          (en_i),
   .start_i       (start_i),
   .abort_i       (abort_i),
   .clr_irq_i     (clr_irq_i),
   .mode_ring_i   (mode_ring_i),
   .mode_clrcnt_i (mode_clrcnt_i),
   .rd_req_o      (rd_req_o),
   .wr_req_o      (wr_req_o),
   .mv_start_o    (mv_start_o),
   .mv_hold_o     (mv_hold_o),
   .mv_abort_o    (mv_abort_o),
   .mv_done_i     (mv_done_i),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .irq_o         (irq_o)
);

// File: tb/sgdma_seq_tb_top.sv
module sgdma_seq_tb_top;

   localparam int CLK_NS = 10;
   localparam int AW  = 32;
   localparam int DW  = 32;
   localparam int CW  = DW - 1;
   localparam int LAT = 6;

   logic clk, rst_n;
   logic en, start, abort, clr_irq, m_ring, m_vstop, m_clr, m_ie;
   logic [AW-5:0] first_hi;
   logic first_space;
   logic rd_req, rd_space, rd_ack, wr_req, wr_space, wr_ack;
   logic [AW-1:0] rd_addr, wr_addr, mv_pci, mv_loc;
   logic [DW-1:0] rd_data, wr_data;
   logic [CW-1:0] mv_cnt;
   logic mv_start, mv_dir, mv_hold, mv_abort, mv_done, busy, done, irq;

   typedef struct {
      logic [31:0] pci;
      logic [31:0] loc;
      logic [30:0] cnt;
      logic        dir;
   } xfer_t;

   xfer_t       exp_q[$];
   logic [31:0] mem [logic [32:0]];
   logic [32:0] rd_log[$];
   int checks = 0;
   int errors = 0;
   int starts = 0;

   sgdma_seq dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en), .start_i(start), .abort_i(abort),
      .clr_irq_i(clr_irq), .mode_ring_i(m_ring), .mode_vstop_i(m_vstop),
      .mode_clrcnt_i(m_clr), .mode_done_ie_i(m_ie), .first_hi_i(first_hi),
      .first_space_i(first_space), .rd_req_o(rd_req), .rd_space_o(rd_space),
      .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
      .wr_req_o(wr_req), .wr_space_o(wr_space), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .wr_ack_i(wr_ack), .mv_start_o(mv_start),
      .mv_pci_addr_o(mv_pci), .mv_loc_addr_o(mv_loc), .mv_count_o(mv_cnt),
      .mv_dir_o(mv_dir), .mv_hold_o(mv_hold), .mv_abort_o(mv_abort),
      .mv_done_i(mv_done), .busy_o(busy), .done_o(done), .irq_o(irq)
   );

   initial clk = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_nxt(input logic [31:0] na, input logic sp,
                                          input logic eoc, input logic tc, input logic dir);
      return {na[31:4], dir, tc, eoc, sp};
   endfunction

   function automatic logic [31:0] rdmem(input logic sp, input logic [31:0] a);
      logic [32:0] k;
      k = {sp, a};
      return mem.exists(k) ? mem[k] : 32'h0;
   endfunction

   task automatic put_desc(input logic sp, input logic [31:0] b, input logic [31:0] pci,
                           input logic [31:0] loc, input logic [31:0] cw, input logic [31:0] nx);
      mem[{sp, b}]         = pci;
      mem[{sp, b + 32'd4}] = loc;
      mem[{sp, b + 32'd8}] = cw;
      mem[{sp, b + 32'd12}] = nx;
   endtask

   task automatic push_exp(input logic [31:0] pci, input logic [31:0] loc,
                           input logic [30:0] cnt, input logic dir);
      xfer_t e;
      e.pci = pci; e.loc = loc; e.cnt = cnt; e.dir = dir;
      exp_q.push_back(e);
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic go(input logic sp, input logic [31:0] b);
      first_hi    = b[31:4];
      first_space = sp;
      pulse_start();
   endtask

   task automatic wait_idle(input string req);
      int t;
      t = 0;
      while (busy && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(!busy, req, "chain finished", 64'(busy), 0);
      repeat (LAT + 4) @(negedge clk);
   endtask

   // Responders for the descriptor read and write-back ports.
   always @(posedge clk) begin
      if (!rst_n) begin
         rd_ack <= 1'b0;
         wr_ack <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_ack <= rd_req && !rd_ack;
         if (rd_req && !rd_ack) begin
            rd_data <= rdmem(rd_space, rd_addr);
            rd_log.push_back({rd_space, rd_addr});
         end
         wr_ack <= wr_req && !wr_ack;
         if (wr_req && !wr_ack) mem[{wr_space, wr_addr}] = wr_data;
      end
   end

   // Data mover model and scoreboard monitor (R2).
   initial begin
      mv_done = 1'b0;
      forever begin
         @(negedge clk);
         if (mv_start) begin
            starts++;
            if (exp_q.size() == 0) begin
               chk(0, "R2", "unexpected transfer count", 64'(mv_cnt), 0);
            end else begin
               xfer_t e;
               e = exp_q.pop_front();
               chk(mv_pci == e.pci, "R2", "pci address", 64'(mv_pci), 64'(e.pci));
               chk(mv_loc == e.loc, "R2", "local address", 64'(mv_loc), 64'(e.loc));
               chk(mv_cnt == e.cnt, "R2", "count", 64'(mv_cnt), 64'(e.cnt));
               chk(mv_dir == e.dir, "R2", "direction", 64'(mv_dir), 64'(e.dir));
            end
            begin
               int n;
               n = 0;
               while (n < LAT && !mv_abort) begin
                  @(negedge clk);
                  if (!mv_hold) n++;
               end
            end
            if (!mv_abort) begin
               mv_done = 1'b1;
               @(negedge clk);
               mv_done = 1'b0;
            end
         end
      end
   end

   initial begin
      #(CLK_NS * 150000);
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; en = 1'b0; start = 1'b0; abort = 1'b0; clr_irq = 1'b0;
      m_ring = 1'b0; m_vstop = 1'b0; m_clr = 1'b0; m_ie = 1'b0;
      first_hi = '0; first_space = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !irq, "R3", "reset state busy/done/irq", {busy, done, irq}, 0);
      chk(!rd_req && !wr_req && !mv_start, "R1", "reset state requests",
          {rd_req, wr_req, mv_start}, 0);

      // R10: start ignored while disabled
      put_desc(1'b0, 32'h100, 32'h8000_0000, 32'h10, 32'h40,
               mk_nxt(32'h200, 1'b1, 1'b0, 1'b0, 1'b1));
      go(1'b0, 32'h100);
      repeat (10) @(negedge clk);
      chk(!busy && rd_log.size() == 0, "R10", "start while disabled",
          64'(rd_log.size()), 0);

      // Basic three-descriptor chain: R1 R2 R3 R9 R13
      en = 1'b1; m_clr = 1'b1; m_ie = 1'b1;
      put_desc(1'b1, 32'h200, 32'h8000_1000, 32'h20, 32'h8,
               mk_nxt(32'h300, 1'b0, 1'b0, 1'b0, 1'b0));
      put_desc(1'b0, 32'h300, 32'h8000_2000, 32'h30, 32'h1234,
               mk_nxt(32'h0, 1'b0, 1'b1, 1'b0, 1'b1));
      push_exp(32'h8000_0000, 32'h10, 31'h40, 1'b1);
      push_exp(32'h8000_1000, 32'h20, 31'h8, 1'b0);
      push_exp(32'h8000_2000, 32'h30, 31'h1234, 1'b1);
      rd_log.delete();
      go(1'b0, 32'h100);
      wait_idle("R3");
      chk(rd_log.size() == 12, "R1", "word reads for three descriptors", 64'(rd_log.size()), 12);
      for (int i = 0; i < 12 && i < rd_log.size(); i++) begin
         logic [32:0] e;
         e = (i < 4) ? {1'b0, 32'h100 + 32'(4*i)} :
             (i < 8) ? {1'b1, 32'h200 + 32'(4*(i-4))} : {1'b0, 32'h300 + 32'(4*(i-8))};
         chk(rd_log[i] == e, "R1", "read address/space order", 64'(rd_log[i]), 64'(e));
      end
      chk(exp_q.size() == 0, "R2", "all chain transfers seen", 64'(exp_q.size()), 0);
      chk(rdmem(1'b0, 32'h108) == 0 && rdmem(1'b1, 32'h208) == 0 && rdmem(1'b0, 32'h308) == 0,
          "R9", "count words cleared", 64'(rdmem(1'b1, 32'h208)), 0);
      chk(done && irq, "R3", "done and irq at end of chain", {done, irq}, 2'b11);
      @(negedge clk) clr_irq = 1'b1;
      @(negedge clk) clr_irq = 1'b0;
      chk(!irq && done, "R13", "irq cleared, done kept", {done, irq}, 2'b10);

      // R4, R9 off, R10 done clears on start
      m_clr = 1'b0; m_ie = 1'b0;
      put_desc(1'b0, 32'h400, 32'h11, 32'h22, 32'h10, mk_nxt(32'h500, 1'b0, 1'b0, 1'b1, 1'b0));
      put_desc(1'b0, 32'h500, 32'h33, 32'h44, 32'h18, mk_nxt(32'h0, 1'b0, 1'b1, 1'b0, 1'b0));
      push_exp(32'h11, 32'h22, 31'h10, 1'b0);
      push_exp(32'h33, 32'h44, 31'h18, 1'b0);
      go(1'b0, 32'h400);
      chk(!done && busy, "R10", "done cleared by accepted start", {done, busy}, 2'b01);
      wait_idle("R4");
      chk(irq && done, "R4", "terminal-count irq with done-ie off", {done, irq}, 2'b11);
      chk(rdmem(1'b0, 32'h408) == 32'h10, "R9", "count word kept when mode off",
          64'(rdmem(1'b0, 32'h408)), 32'h10);
      @(negedge clk) clr_irq = 1'b1;
      @(negedge clk) clr_irq = 1'b0;
      push_exp(32'h33, 32'h44, 31'h18, 1'b0);
      go(1'b0, 32'h500);
      wait_idle("R3");
      chk(!irq && done, "R3", "no irq with done-ie off and no tc bit", {done, irq}, 2'b10);

      // R5: valid flag ignored when ring mode is off
      put_desc(1'b1, 32'h580, 32'h55, 32'h66, 32'h0000_0020, mk_nxt(32'h0, 1'b0, 1'b1, 1'b0, 1'b1));
      push_exp(32'h55, 32'h66, 31'h20, 1'b1);
      go(1'b1, 32'h580);
      wait_idle("R5");
      chk(exp_q.size() == 0, "R5", "invalid-flag descriptor transferred", 64'(exp_q.size()), 0);

      // R6: ring mode zero-count skip and zero-count end
      m_ring = 1'b1; m_clr = 1'b1;
      put_desc(1'b0, 32'h600, 32'h77, 32'h88, 32'h8000_0000, mk_nxt(32'h700, 1'b0, 1'b0, 1'b0, 1'b0));
      put_desc(1'b0, 32'h700, 32'h99, 32'hAA, 32'h8000_0010, mk_nxt(32'h0, 1'b0, 1'b1, 1'b0, 1'b0));
      push_exp(32'h99, 32'hAA, 31'h10, 1'b0);
      go(1'b0, 32'h600);
      wait_idle("R6");
      chk(exp_q.size() == 0, "R6", "only nonzero descriptor transferred", 64'(exp_q.size()), 0);
      chk(rdmem(1'b0, 32'h608) == 32'h8000_0000, "R6", "skipped descriptor not written",
          64'(rdmem(1'b0, 32'h608)), 32'h8000_0000);
      put_desc(1'b0, 32'h800, 32'h1, 32'h2, 32'h8000_0000, mk_nxt(32'h0, 1'b0, 1'b1, 1'b0, 1'b0));
      begin
         int s0;
         s0 = starts;
         go(1'b0, 32'h800);
         wait_idle("R6");
         chk(starts == s0 && done, "R6", "zero-count end completes without launch",
             64'(starts - s0), 0);
      end
      chk(rdmem(1'b0, 32'h808) == 0, "R9", "zero-count end written back", 64'(rdmem(1'b0, 32'h808)), 0);

      // R7: invalid descriptor re-polled
      m_vstop = 1'b0;
      put_desc(1'b0, 32'h900, 32'hB1, 32'hB2, 32'h0000_0030, mk_nxt(32'h0, 1'b0, 1'b1, 1'b0, 1'b0));
      push_exp(32'hB1, 32'hB2, 31'h30, 1'b0);
      rd_log.delete();
      go(1'b0, 32'h900);
      while (rd_log.size() < 12) @(negedge clk);
      chk(exp_q.size() == 1 && busy, "R7", "no launch while invalid", 64'(exp_q.size()), 1);
      mem[{1'b0, 32'h908}] = 32'h8000_0030;
      wait_idle("R7");
      chk(exp_q.size() == 0, "R7", "launch after flag set", 64'(exp_q.size()), 0);

      // R8: invalid descriptor parks the channel
      m_vstop = 1'b1;
      put_desc(1'b0, 32'hA00, 32'hC1, 32'hC2, 32'h0000_0040, mk_nxt(32'h0, 1'b0, 1'b1, 1'b0, 1'b0));
      push_exp(32'hC1, 32'hC2, 31'h40, 1'b0);
      rd_log.delete();
      go(1'b0, 32'hA00);
      repeat (40) @(negedge clk);
      chk(rd_log.size() == 4 && busy && exp_q.size() == 1, "R8", "parked after one read",
          64'(rd_log.size()), 4);
      mem[{1'b0, 32'hA08}] = 32'h8000_0040;
      pulse_start();
      wait_idle("R8");
      chk(exp_q.size() == 0 && rd_log.size() == 8, "R8", "resumed by start", 64'(rd_log.size()), 8);
      m_ring = 1'b0; m_vstop = 1'b0;

      // R11: pause during a transfer
      put_desc(1'b0, 32'hB00, 32'hD1, 32'hD2, 32'h50, mk_nxt(32'h0, 1'b0, 1'b1, 1'b0, 1'b0));
      push_exp(32'hD1, 32'hD2, 31'h50, 1'b0);
      begin
         int s0;
         s0 = starts;
         go(1'b0, 32'hB00);
         while (starts == s0) @(negedge clk);
      end
      en = 1'b0;
      @(negedge clk);
      chk(mv_hold, "R11", "hold while disabled", 64'(mv_hold), 1);
      repeat (30) @(negedge clk);
      chk(busy && mv_hold, "R11", "no completion while paused", {busy, mv_hold}, 2'b11);
      en = 1'b1;
      wait_idle("R11");
      chk(done && exp_q.size() == 0, "R11", "completes after resume", 64'(done), 1);

      // R12: abort ignored when enabled, honoured when disabled
      put_desc(1'b0, 32'hC00, 32'hE1, 32'hE2, 32'h60, mk_nxt(32'hD00, 1'b0, 1'b0, 1'b0, 1'b0));
      put_desc(1'b0, 32'hD00, 32'hF1, 32'hF2, 32'h70, mk_nxt(32'h0, 1'b0, 1'b1, 1'b0, 1'b0));
      push_exp(32'hE1, 32'hE2, 31'h60, 1'b0);
      begin
         int s0;
         s0 = starts;
         go(1'b0, 32'hC00);
         while (starts == s0) @(negedge clk);
      end
      @(negedge clk) abort = 1'b1;
      @(negedge clk) abort = 1'b0;
      chk(busy && !done && !mv_abort, "R12", "abort ignored while enabled",
          {busy, done, mv_abort}, 3'b100);
      en = 1'b0;
      @(negedge clk) abort = 1'b1;
      @(negedge clk) abort = 1'b0;
      chk(mv_abort && done && !busy, "R12", "abort honoured while disabled",
          {mv_abort, done, busy}, 3'b110);
      repeat (LAT + 10) @(negedge clk);
      chk(exp_q.size() == 0 && !busy, "R12", "second descriptor never launched",
          64'(exp_q.size()), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule